// File: doc/BRIEF.md
# Streaming Window Pooling Stage

This block takes a single feature-map plane as a raster-ordered stream of signed pixels, one pixel per beat on which `inValid` is high. It reduces the plane with a small sliding or tiling window. A 4-bit operation code selects the window. The available reductions are pass-through, maximum, arithmetic mean, and taking a fixed corner of each window. The window is 2x2 or 4x4. The stride equals the window size, except for two codes that move a 2x2 window one pixel at a time. The plane size is given as width-minus-one and height-minus-one.

The reduced plane leaves in raster order, one result per strobe on `outValid`. `outLast` marks the final result of the plane. There is no back-pressure. Each result appears on the clock after the input beat that completes its window. The operation code and the size fields must be held steady for the whole plane.

Top module: `poolUnit`

## Requirements
- R1: With code 0, every input beat produces one output equal to that pixel, on the next clock.
- R2: With code 1, each output is the largest pixel of a 2x2 tile, with stride 2. With code 3, each output is the largest pixel of a 4x4 tile, with stride 4.
- R3: Codes 2 and 4 give the mean of a 2x2 tile (stride 2) and of a 4x4 tile (stride 4). The mean is the signed tile sum shifted arithmetically right by 2 or by 4, so it rounds toward negative infinity.
- R4: Codes 5 and 6 output the upper-left and the upper-right pixel of each 2x2 tile, with stride 2. Code 7 outputs the upper-left pixel of each 4x4 tile, with stride 4.
- R5: Code 8 gives the floored mean and code 9 gives the maximum of each 2x2 window, moved one pixel at a time. The result is a (W-1)x(H-1) plane with no padding.
- R6: In tiling modes, columns and rows past the last complete tile produce no output. A plane smaller than one window produces no output at all.
- R7: `outLast` is high together with the final output of each plane, and at no other time.
- R8: Codes 10 through 15 behave exactly like code 0.
- R9: During and directly after reset, `outValid` and `outLast` are low.
- R10: Each output is strobed on the clock after the beat that brings in the bottom-right pixel of its window, and the outputs leave in raster order. No output appears on a clock that does not follow an accepted beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input pixel present on this clock |
| inPix | input | 8 | Signed input pixel |
| cfgPoolType | input | 4 | Operation code (0..15) |
| cfgWidthM1 | input | 10 | Plane width minus one |
| cfgHeightM1 | input | 9 | Plane height minus one |
| outValid | output | 1 | Output pixel present |
| outPix | output | 8 | Signed output pixel |
| outLast | output | 1 | Final output of the plane |

## Verification
A column or row counter that is off by one shows up at the ports within a single window. Results then fall on the wrong beat or leave the plane in the wrong number, and the per-clock comparison against the beat-indexed model catches this on the next strobe. A corrupted column store entry or horizontal accumulator shows up as a wrong value in the next result that uses that column. A phase error in the last-pixel logic shows up at the end of the plane, as a missing or extra `outLast` or as leftover expected results.

// File: rtl/poolPkg.sv
package poolPkg;

  typedef enum logic [2:0] {
    OP_BYPASS,
    OP_MAX,
    OP_MEAN,
    OP_PICK_LEFT,
    OP_PICK_RIGHT
  } poolOpE;

  typedef struct packed {
    poolOpE     op;
    logic [1:0] winLog;   // log2 of window side
    logic       slide;    // stride-1 window
  } poolModeS;

  typedef struct packed {
    logic beat;
    logic rowStart;
    logic colStart;
    logic slide;
    logic emit;
    logic last;
  } poolStrobeS;

  function automatic poolModeS decodeMode(input logic [3:0] code);
    poolModeS m;
    m = '{op: OP_BYPASS, winLog: 2'd0, slide: 1'b0};
    case (code)
      4'd1: m = '{op: OP_MAX,        winLog: 2'd1, slide: 1'b0};
      4'd2: m = '{op: OP_MEAN,       winLog: 2'd1, slide: 1'b0};
      4'd3: m = '{op: OP_MAX,        winLog: 2'd2, slide: 1'b0};
      4'd4: m = '{op: OP_MEAN,       winLog: 2'd2, slide: 1'b0};
      4'd5: m = '{op: OP_PICK_LEFT,  winLog: 2'd1, slide: 1'b0};
      4'd6: m = '{op: OP_PICK_RIGHT, winLog: 2'd1, slide: 1'b0};
      4'd7: m = '{op: OP_PICK_LEFT,  winLog: 2'd2, slide: 1'b0};
      4'd8: m = '{op: OP_MEAN,       winLog: 2'd1, slide: 1'b1};
      4'd9: m = '{op: OP_MAX,        winLog: 2'd1, slide: 1'b1};
      default: m = '{op: OP_BYPASS,  winLog: 2'd0, slide: 1'b0};
    endcase
    return m;
  endfunction

endpackage

// File: rtl/poolCtrl.sv
module poolCtrl
  import poolPkg::*;
#(
  parameter int WIDTH_BITS  = 10,
  parameter int HEIGHT_BITS = 9
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   inValid,
  input  logic [1:0]             winLog,
  input  logic                   slide,
  input  logic [WIDTH_BITS-1:0]  widthM1,
  input  logic [HEIGHT_BITS-1:0] heightM1,
  output poolStrobeS             strobe,
  output logic [WIDTH_BITS-1:0]  colAddr
);

  localparam int WX = WIDTH_BITS + 1;
  localparam int HX = HEIGHT_BITS + 1;

  logic [WIDTH_BITS-1:0]  colCnt;
  logic [HEIGHT_BITS-1:0] rowCnt;

  logic [WX-1:0] maskW, widthFull, widthFloor, colExt;
  logic [HX-1:0] maskH, heightFull, heightFloor, rowExt;
  logic          colPhaseEnd, rowPhaseEnd, colPhaseZero, rowPhaseZero;
  logic          tileEmit, tileLast, slideEmit, slideLast;

  always_comb begin
    maskW       = (WX'(1) << winLog) - WX'(1);
    maskH       = (HX'(1) << winLog) - HX'(1);
    colExt      = {1'b0, colCnt};
    rowExt      = {1'b0, rowCnt};
    widthFull   = {1'b0, widthM1} + WX'(1);
    heightFull  = {1'b0, heightM1} + HX'(1);
    widthFloor  = widthFull & ~maskW;
    heightFloor = heightFull & ~maskH;

    colPhaseEnd  = (colExt & maskW) == maskW;
    rowPhaseEnd  = (rowExt & maskH) == maskH;
    colPhaseZero = (colExt & maskW) == '0;
    rowPhaseZero = (rowExt & maskH) == '0;

    tileEmit  = colPhaseEnd && rowPhaseEnd &&
                (colExt < widthFloor) && (rowExt < heightFloor);
    tileLast  = tileEmit && (colExt == widthFloor - WX'(1)) &&
                (rowExt == heightFloor - HX'(1));
    slideEmit = (colCnt != '0) && (rowCnt != '0);
    slideLast = slideEmit && (colCnt == widthM1) && (rowCnt == heightM1);

    strobe.beat     = inValid;
    strobe.slide    = slide;
    strobe.rowStart = slide ? (rowCnt == '0) : rowPhaseZero;
    strobe.colStart = slide ? (colCnt == '0) : colPhaseZero;
    strobe.emit     = inValid && (slide ? slideEmit : tileEmit);
    strobe.last     = inValid && (slide ? slideLast : tileLast);
    colAddr         = colCnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      colCnt <= '0;
      rowCnt <= '0;
    end else if (inValid) begin
      if (colCnt == widthM1) begin
        colCnt <= '0;
        rowCnt <= (rowCnt == heightM1) ? '0 : rowCnt + 1'b1;
      end else begin
        colCnt <= colCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/poolDatapath.sv
module poolDatapath
  import poolPkg::*;
#(
  parameter int PIX_W      = 8,
  parameter int WIDTH_BITS = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  poolOpE                  op,
  input  logic [1:0]              winLog,
  input  poolStrobeS              strobe,
  input  logic [WIDTH_BITS-1:0]   colAddr,
  input  logic signed [PIX_W-1:0] inPix,
  output logic                    outValid,
  output logic signed [PIX_W-1:0] outPix,
  output logic                    outLast
);

  localparam int GUARD = 4;               // headroom for a 16-pixel sum
  localparam int ACC_W = PIX_W + GUARD;
  localparam int DEPTH = 1 << WIDTH_BITS;

  logic signed [ACC_W-1:0] colMem [DEPTH];
  logic signed [ACC_W-1:0] horzReg;
  logic signed [ACC_W-1:0] pixExt, colRead, vertVal, horzVal, scaled;
  logic [2:0]              shiftAmt;

  function automatic logic signed [ACC_W-1:0] merge(
    input poolOpE                  mode,
    input logic signed [ACC_W-1:0] older,
    input logic signed [ACC_W-1:0] newer,
    input logic                    vertical
  );
    case (mode)
      OP_MAX:        return (older > newer) ? older : newer;
      OP_MEAN:       return older + newer;
      OP_PICK_LEFT:  return older;
      OP_PICK_RIGHT: return vertical ? older : newer;
      default:       return newer;
    endcase
  endfunction

  always_comb begin
    pixExt   = {{GUARD{inPix[PIX_W-1]}}, inPix};
    colRead  = colMem[colAddr];
    vertVal  = strobe.rowStart ? pixExt : merge(op, colRead, pixExt, 1'b1);
    horzVal  = strobe.colStart ? vertVal : merge(op, horzReg, vertVal, 1'b0);
    shiftAmt = (op == OP_MEAN) ? {winLog, 1'b0} : 3'd0;
    scaled   = horzVal >>> shiftAmt;
  end

  always_ff @(posedge clk) begin
    if (strobe.beat) begin
      colMem[colAddr] <= strobe.slide ? pixExt : vertVal;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      horzReg  <= '0;
      outValid <= 1'b0;
      outLast  <= 1'b0;
      outPix   <= '0;
    end else begin
      outValid <= strobe.emit;
      outLast  <= strobe.last;
      if (strobe.beat) horzReg <= strobe.slide ? vertVal : horzVal;
      if (strobe.emit) outPix  <= scaled[PIX_W-1:0];
    end
  end

endmodule

// File: rtl/poolUnit.sv
module poolUnit
  import poolPkg::*;
#(
  parameter int PIX_W       = 8,
  parameter int WIDTH_BITS  = 10,
  parameter int HEIGHT_BITS = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    inValid,
  input  logic signed [PIX_W-1:0] inPix,
  input  logic [3:0]              cfgPoolType,
  input  logic [WIDTH_BITS-1:0]   cfgWidthM1,
  input  logic [HEIGHT_BITS-1:0]  cfgHeightM1,
  output logic                    outValid,
  output logic signed [PIX_W-1:0] outPix,
  output logic                    outLast
);

  poolModeS              mode;
  poolStrobeS            strobe;
  logic [WIDTH_BITS-1:0] colAddr;

  assign mode = decodeMode(cfgPoolType);

  poolCtrl #(.WIDTH_BITS(WIDTH_BITS), .HEIGHT_BITS(HEIGHT_BITS)) i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .winLog   (mode.winLog),
    .slide    (mode.slide),
    .widthM1  (cfgWidthM1),
    .heightM1 (cfgHeightM1),
    .strobe   (strobe),
    .colAddr  (colAddr)
  );

  poolDatapath #(.PIX_W(PIX_W), .WIDTH_BITS(WIDTH_BITS)) i_data (
    .clk      (clk),
    .rst      (rst),
    .op       (mode.op),
    .winLog   (mode.winLog),
    .strobe   (strobe),
    .colAddr  (colAddr),
    .inPix    (inPix),
    .outValid (outValid),
    .outPix   (outPix),
    .outLast  (outLast)
  );

endmodule

// File: rtl/poolUnitChk.sv
module poolUnitChk #(
  parameter int PIX_W = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    inValid,
  input logic signed [PIX_W-1:0] inPix,
  input logic [3:0]              cfgPoolType,
  input logic                    outValid,
  input logic signed [PIX_W-1:0] outPix,
  input logic                    outLast
);

  // R9: reset leaves the output side quiet
  a_r9_reset_quiet: assert property (@(posedge clk)
    rst |=> (!outValid && !outLast));

  // R7: the last flag only rides on a valid result
  a_r7_last_has_valid: assert property (@(posedge clk) disable iff (rst)
    outLast |-> outValid);

  // R10: a result always follows an accepted beat
  a_r10_needs_beat: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(inValid));

  // R1: code 0 forwards each pixel on the next clock
  a_r1_bypass_forward: assert property (@(posedge clk) disable iff (rst)
    (inValid && cfgPoolType == 4'd0) |=> (outValid && outPix == $past(inPix)));

  // R8: codes 10..15 forward like code 0
  a_r8_high_codes_forward: assert property (@(posedge clk) disable iff (rst)
    (inValid && cfgPoolType >= 4'd10) |=> (outValid && outPix == $past(inPix)));

endmodule

bind poolUnit poolUnitChk #(.PIX_W(PIX_W)) i_poolUnitChk (
  .clk         (clk),
  .rst         (rst),
  .inValid     (inValid),
  .inPix       (inPix),
  .cfgPoolType (cfgPoolType),
  .outValid    (outValid),
  .outPix      (outPix),
  .outLast     (outLast)
);

// File: tb/test_poolUnit.sv
module test_poolUnit;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              inValid = 1'b0;
  logic signed [7:0] inPix = '0;
  logic [3:0]        cfgPoolType = '0;
  logic [9:0]        cfgWidthM1 = '0;
  logic [8:0]        cfgHeightM1 = '0;
  logic              outValid;
  logic signed [7:0] outPix;
  logic              outLast;

  int checks = 0;
  int fails  = 0;

  int img [32][32];
  int qPix[$];
  int qLast[$];
  int qBeat[$];

  always #10 clk = ~clk;   // 50 MHz

  poolUnit i_poolUnit (
    .clk(clk), .rst(rst), .inValid(inValid), .inPix(inPix),
    .cfgPoolType(cfgPoolType), .cfgWidthM1(cfgWidthM1),
    .cfgHeightM1(cfgHeightM1), .outValid(outValid), .outPix(outPix),
    .outLast(outLast)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int winValue(input int code, input int y0, input int x0, input int k);
    int best, sum, sh;
    best = -1000; sum = 0;
    for (int dy = 0; dy < k; dy++)
      for (int dx = 0; dx < k; dx++) begin
        if (img[y0+dy][x0+dx] > best) best = img[y0+dy][x0+dx];
        sum += img[y0+dy][x0+dx];
      end
    sh = (k == 4) ? 4 : 2;
    case (code)
      1, 3, 9: return best;
      2, 4, 8: return sum >>> sh;
      6:       return img[y0][x0+1];
      default: return img[y0][x0];
    endcase
  endfunction

  // Builds the expected results, each tagged with the beat that completes it.
  task automatic buildModel(input int code, input int w, input int h);
    int k, nx, ny;
    qPix.delete(); qLast.delete(); qBeat.delete();
    if (code == 8 || code == 9) begin
      for (int oy = 0; oy < h - 1; oy++)
        for (int ox = 0; ox < w - 1; ox++) begin
          qPix.push_back(winValue(code, oy, ox, 2));
          qBeat.push_back((oy + 1) * w + ox + 1);
          qLast.push_back(int'(oy == h - 2 && ox == w - 2));
        end
    end else if (code >= 1 && code <= 7) begin
      k  = (code == 3 || code == 4 || code == 7) ? 4 : 2;
      nx = w / k; ny = h / k;
      for (int oy = 0; oy < ny; oy++)
        for (int ox = 0; ox < nx; ox++) begin
          qPix.push_back(winValue(code, oy * k, ox * k, k));
          qBeat.push_back((oy * k + k - 1) * w + ox * k + k - 1);
          qLast.push_back(int'(oy == ny - 1 && ox == nx - 1));
        end
    end else begin
      for (int y = 0; y < h; y++)
        for (int x = 0; x < w; x++) begin
          qPix.push_back(img[y][x]);
          qBeat.push_back(y * w + x);
          qLast.push_back(int'(y == h - 1 && x == w - 1));
        end
    end
  endtask

  // One clock: drive at the falling edge, compare after the next falling edge.
  task automatic step(input int beat, input int w, input string tag);
    inValid = (beat >= 0);
    inPix   = (beat >= 0) ? 8'(img[beat / w][beat % w]) : 8'sd0;
    @(posedge clk);
    @(negedge clk);
    if (outValid) begin
      if (qBeat.size() == 0 || qBeat[0] != beat) begin
        check(1'b0, tag, "R10 unexpected result at beat", beat,
              (qBeat.size() == 0) ? -1 : qBeat[0]);
      end else begin
        check(outPix == 8'(qPix[0]), tag, "pixel", int'(outPix), qPix[0]);
        check(outLast == qLast[0][0], tag, "R7 last flag", int'(outLast), qLast[0]);
        void'(qPix.pop_front()); void'(qLast.pop_front()); void'(qBeat.pop_front());
      end
    end else if (qBeat.size() != 0 && qBeat[0] == beat && beat >= 0) begin
      check(1'b0, tag, "R10 missing result at beat", -1, beat);
      void'(qPix.pop_front()); void'(qLast.pop_front()); void'(qBeat.pop_front());
    end else if (outLast) begin
      check(1'b0, tag, "R7 stray last", 1, 0);
    end
  endtask

  task automatic runFrame(input int code, input int w, input int h,
                          input int fill, input string tag);
    for (int y = 0; y < h; y++)
      for (int x = 0; x < w; x++)
        img[y][x] = (fill == 999) ? int'($urandom_range(0, 255)) - 128 : fill;
    buildModel(code, w, h);
    cfgPoolType = 4'(code);
    cfgWidthM1  = 10'(w - 1);
    cfgHeightM1 = 9'(h - 1);
    for (int b = 0; b < w * h; b++) begin
      if ($urandom_range(0, 3) == 0) step(-1, w, tag);
      step(b, w, tag);
    end
    step(-1, w, tag);
    step(-1, w, tag);
    check(qPix.size() == 0, tag, "R6 results left unseen", qPix.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R9", "outValid in reset", int'(outValid), 0);
    check(outLast == 1'b0, "R9", "outLast in reset", int'(outLast), 0);
    rst = 1'b0;
    @(negedge clk);
    check(outValid == 1'b0, "R9", "outValid after reset", int'(outValid), 0);

    runFrame(0, 5, 3, 999, "R1");
    runFrame(1, 8, 6, 999, "R2");
    runFrame(3, 10, 9, 999, "R2 R6");
    runFrame(2, 7, 5, 999, "R3 R6");
    runFrame(4, 8, 8, 999, "R3");
    runFrame(4, 4, 4, -128, "R3 min");
    runFrame(2, 4, 2, -1, "R3 floor");
    runFrame(5, 6, 4, 999, "R4 left2");
    runFrame(6, 6, 4, 999, "R4 right2");
    runFrame(7, 9, 8, 999, "R4 left4");
    runFrame(8, 6, 5, 999, "R5 mean");
    runFrame(9, 7, 4, 999, "R5 max");
    runFrame(12, 4, 3, 999, "R8");
    runFrame(15, 3, 2, 999, "R8");
    runFrame(1, 1, 1, 999, "R6 tiny");
    runFrame(3, 3, 5, 999, "R6 narrow");
    runFrame(9, 1, 4, 999, "R5 single column");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule